// File: doc/BRIEF.md
# Two-Agent Quantum Bus Arbiter

This block decides which of two agents, a transmit path and a receive path, may drive a shared internal bus. Each agent raises a request, waits for its grant, moves data while the grant is high, and may end its turn early with a done pulse. The arbiter never grants both agents at once. It caps every turn at a fixed quantum of clock cycles, sized so that a 128-byte buffer drains over a 32-bit path in one turn.

Turns alternate between the agents. When a turn ends and the other agent is waiting, the other agent goes next. When both agents ask at the same moment and no turn has been taken yet, the receive agent wins. There is always one idle cycle between one grant falling and the next rising, so two drivers never overlap on the bus.

Top module: `quantum_arbiter`

## Requirements
- R1: `rx_gnt` and `tx_gnt` are never high in the same cycle.
- R2: When no grant is held and the arbiter has not issued a grant since reset, a request from both agents on the same edge grants receive (`rx_gnt`) on that edge. A lone request is granted on the edge that samples it.
- R3: A grant stays high for at most QUANTUM (default 32) consecutive cycles. It falls after the QUANTUM-th cycle even if the holder still requests.
- R4: If the holder has done high on an edge where it holds the grant, its grant is low from that edge on.
- R5: When a grant falls and the other agent requests during the idle cycle that follows, the other agent is granted next. If only the previous holder requests, the previous holder is granted again with a fresh quantum.
- R6: A done input from the agent that does not hold the grant has no effect on either grant.
- R7: After a grant falls, both grants stay low for at least one full cycle before any grant rises.
- R8: If the holder drops its request while granted, its grant falls on the next edge.
- R9: Synchronous active-high `rst` clears both grants and the quantum counter, and gives priority on the next tie to the receive agent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_req | input | 1 | Receive agent requests the bus |
| rx_done | input | 1 | Receive agent ends its turn early |
| tx_req | input | 1 | Transmit agent requests the bus |
| tx_done | input | 1 | Transmit agent ends its turn early |
| rx_gnt | output | 1 | Bus granted to the receive agent |
| tx_gnt | output | 1 | Bus granted to the transmit agent |

## Verification
The embedded properties assume that the requests and dones are synchronous to the clock, never unknown, and free of glitches. They also assume that a request seen in the idle cycle after a hand-off is the one that counts for alternation. The bench meets these assumptions by changing every input only on the falling edge from one driver task. Its stimulus runs directed phases first: a tie after reset, a continuous request through expiry, an early done, a foreign done, and a dropped request. A long pseudo-random phase follows, in which both agents request often and raise done only rarely, so that expiry and alternation keep recurring.

// File: rtl/quantum_arbiter.sv
module quantum_arbiter #(
  parameter int QUANTUM = 32,
  localparam int CW = (QUANTUM > 1) ? $clog2(QUANTUM) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_req,
  input  logic rx_done,
  input  logic tx_req,
  input  logic tx_done,
  output logic rx_gnt,
  output logic tx_gnt
);

  localparam logic [CW-1:0] LAST = CW'(QUANTUM - 1);

  logic [CW-1:0] cnt;
  logic          pri_rx;

  wire held      = rx_gnt | tx_gnt;
  wire hold_req  = rx_gnt ? rx_req  : tx_req;
  wire hold_done = rx_gnt ? rx_done : tx_done;
  wire expire    = (cnt == LAST);
  wire release_now = held && (!hold_req || hold_done || expire);
  wire pick_rx   = rx_req && (!tx_req || pri_rx);
  wire pick_tx   = tx_req && !pick_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_gnt <= 1'b0;
      tx_gnt <= 1'b0;
      cnt    <= '0;
      pri_rx <= 1'b1;
    end else if (held) begin
      if (release_now) begin
        rx_gnt <= 1'b0;
        tx_gnt <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else begin
      rx_gnt <= pick_rx;
      tx_gnt <= pick_tx;
      cnt    <= '0;
      if (pick_rx)      pri_rx <= 1'b0;
      else if (pick_tx) pri_rx <= 1'b1;
    end
  end

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_gnt, tx_gnt}));

  // R9
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!rx_gnt && !tx_gnt));

  // R3
  quantum_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (held && expire) |=> (!rx_gnt && !tx_gnt));

  // R4
  rx_done_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_gnt && rx_done) |=> !rx_gnt);

  // R4
  tx_done_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_gnt && tx_done) |=> !tx_gnt);

  // R7
  idle_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rx_gnt) || $fell(tx_gnt)) |-> (!rx_gnt && !tx_gnt));

  // R5
  rr_to_tx_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rx_gnt) && tx_req) |=> tx_gnt);

  // R5
  rr_to_rx_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(tx_gnt) && rx_req) |=> rx_gnt);

  // R6
  foreign_done_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_gnt && tx_req && !tx_done && !expire && rx_done) |=> tx_gnt);

endmodule

// File: tb/test_quantum_arbiter.sv
module test_quantum_arbiter;
  localparam int Q = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_req = 1'b0, rx_done = 1'b0, tx_req = 1'b0, tx_done = 1'b0;
  logic rx_gnt, tx_gnt;

  always #5 clk = ~clk;

  quantum_arbiter #(.QUANTUM(Q)) i_quantum_arbiter (
    .clk(clk), .rst(rst),
    .rx_req(rx_req), .rx_done(rx_done),
    .tx_req(tx_req), .tx_done(tx_done),
    .rx_gnt(rx_gnt), .tx_gnt(tx_gnt)
  );

  typedef struct {
    logic  rx;
    logic  tx;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  logic m_rx = 1'b0, m_tx = 1'b0, m_pri = 1'b1, m_dropped = 1'b0;
  int   m_cnt = 0;

  task automatic cyc(input logic rr, input logic rd, input logic tr,
                     input logic td, input logic rs);
    exp_t e;
    logic hr, hd, prx, ptx;
    @(negedge clk);
    rx_req = rr; rx_done = rd; tx_req = tr; tx_done = td; rst = rs;
    e.tag = "R1";
    if (rs) begin
      m_rx = 0; m_tx = 0; m_cnt = 0; m_pri = 1; m_dropped = 0;
      e.tag = "R9";
    end else if (m_rx || m_tx) begin
      hr = m_rx ? rr : tr;
      hd = m_rx ? rd : td;
      if (!hr || hd || m_cnt == Q - 1) begin
        e.tag = hd ? "R4 R7" : (!hr ? "R8 R7" : "R3 R7");
        m_rx = 0; m_tx = 0; m_cnt = 0; m_dropped = 1;
      end else begin
        if ((m_rx && td) || (m_tx && rd)) e.tag = "R6";
        m_cnt++;
      end
    end else begin
      prx = rr && (!tr || m_pri);
      ptx = tr && !prx;
      if (prx || ptx) begin
        if (m_dropped) e.tag = "R5";
        else if (rr && tr) e.tag = "R2";
      end
      m_rx = prx; m_tx = ptx; m_cnt = 0; m_dropped = 0;
      if (prx) m_pri = 0;
      else if (ptx) m_pri = 1;
    end
    e.rx = m_rx; e.tx = m_tx;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_cmp++;
      if (rx_gnt !== e.rx || tx_gnt !== e.tx) begin
        n_bad++;
        $display("FAIL %s: got rx_gnt=%b tx_gnt=%b, expected rx_gnt=%b tx_gnt=%b",
                 e.tag, rx_gnt, tx_gnt, e.rx, e.tx);
      end
      if (rx_gnt && tx_gnt) begin
        n_cmp++; n_bad++;
        $display("FAIL R1: got both grants 1, expected at most one");
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: got run still active, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) cyc(0, 0, 0, 0, 1);
    // R2 tie after reset, then R3 expiry, R7 gap, R5 hand-off to tx
    repeat (40) cyc(1, 0, 1, 0, 0);
    // R4 early done by tx
    repeat (4) cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 1, 1, 0);
    repeat (3) cyc(0, 0, 0, 0, 0);
    // R5 lone holder re-granted after expiry
    repeat (70) cyc(1, 0, 0, 0, 0);
    repeat (2) cyc(0, 0, 0, 0, 0);
    // R6 foreign done while rx holds, R8 request drop
    cyc(1, 0, 0, 0, 0);
    repeat (5) cyc(1, 0, 0, 1, 0);
    repeat (3) cyc(1, 0, 1, 1, 0);
    cyc(0, 0, 1, 0, 0);
    repeat (5) cyc(0, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    repeat (2) cyc(0, 0, 0, 0, 0);
    // R9 mid-run reset restores rx priority, R2 tie
    cyc(1, 0, 0, 0, 0);
    repeat (3) cyc(1, 0, 1, 0, 0);
    repeat (2) cyc(1, 0, 1, 0, 1);
    repeat (3) cyc(1, 0, 1, 0, 0);
    repeat (2) cyc(0, 0, 0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 3000; i++)
      cyc($urandom_range(0, 9) < 7, $urandom_range(0, 15) == 0,
          $urandom_range(0, 9) < 7, $urandom_range(0, 15) == 0, 1'b0);
    cyc(0, 0, 0, 0, 0);
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule